// File: doc/BRIEF.md
# Block Type Transition Filter

This block decides the caching priority of a line in a large set-associative cache whenever the line's access type changes. An access is either *leading* or *following*: a leading access is the first touch of a region after its tags went cold, and a following access hits tags that are already held on chip. Leading lines get high priority. A line that drops to following normally loses it.

Some lines flip type again and again. Demoting them on each flip leads to early eviction and to an expensive leading miss later. The filter keeps a 2-bit score per line to catch these lines. Each return to following after a short leading run adds two to the score. Each return after a long run removes one, and the score never goes below zero. A non-zero score holds the line at high priority.

Each line also keeps its last type and a short run-length count. The cache controller presents one access per cycle: a line index and the observed type. One cycle later the block returns the priority bit and the score to write back, plus flags for the observed type and for a type change.

Top module: `type_flip_filter`

## Requirements
- R1: After reset every line holds type following, a run length counted as long (3), score 0 and priority 0. No result is flagged valid until an access arrives.
- R2: An access presented with `acc_valid` high yields `res_valid` high exactly one clock later. `res_valid` is low in any cycle that follows a clock with no access.
- R3: A change from following to leading (`acc_type` 1 = leading, 0 = following) returns priority 1 and leaves the score unchanged.
- R4: A change from leading to following after a leading run of 1 or 2 accesses adds 2 to the score, saturating at 3.
- R5: A change from leading to following after a leading run of 3 or more accesses subtracts 1 from the score. A score of 0 stays 0.
- R6: On a change from leading to following, the returned priority is 1 when the updated score is non-zero and 0 when it is zero.
- R7: An access whose type equals the line's stored type returns `res_flip` 0, the stored priority and the stored score, all unchanged.
- R8: The run length counts consecutive same-type accesses to a line. The access that changes the type counts as 1. The count saturates at 3.
- R9: Lines are independent. An access to one line never alters the state that another line reports.

Ports, all in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_line | input | IDX_W (4) | Index of the accessed line |
| acc_type | input | 1 | Observed type: 1 leading, 0 following |
| res_valid | output | 1 | Result of the previous cycle's access |
| res_type | output | 1 | Observed type of that access |
| res_flip | output | 1 | The access changed the line's type |
| res_prio | output | 1 | Priority bit to store for the line |
| res_cnt | output | CNT_W (2) | Updated transition score |

## Verification
A wrong score or run length stays hidden inside a line. It shows at the ports only on that line's next change to following, when the returned score and priority differ from the expected ones. A corrupted stored type shows on the next access to the line, as a wrong `res_flip` one cycle after that access. The bench therefore drives each line through long and short leading runs several times in a row, interleaves other lines, and compares every result.

// File: rtl/tff_pkg.sv
package tff_pkg;
  localparam int RUN_W    = 2;
  localparam int CNT_W    = 2;
  localparam int QUAL_MAX = 2;
  localparam int RUN_MAX  = (1 << RUN_W) - 1;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;

  typedef struct packed {
    logic             typ;
    logic [RUN_W-1:0] run;
    logic [CNT_W-1:0] cnt;
    logic             prio;
  } line_st_t;

  localparam line_st_t LINE_RST = '{typ: 1'b0, run: RUN_W'(RUN_MAX),
                                    cnt: '0, prio: 1'b0};
endpackage

// File: rtl/flip_rule.sv
module flip_rule
  import tff_pkg::*;
(
  input  line_st_t cur,
  input  logic     obs_type,
  output line_st_t nxt,
  output logic     flip,
  output logic     qual
);
  logic [CNT_W:0] cnt_sum;

  always_comb begin
    flip    = (obs_type != cur.typ);
    qual    = (int'(cur.run) <= QUAL_MAX);
    cnt_sum = {1'b0, cur.cnt} + (CNT_W+1)'(2);
    nxt     = cur;
    nxt.typ = obs_type;
    if (flip) begin
      nxt.run = RUN_W'(1);
    end else if (int'(cur.run) != RUN_MAX) begin
      nxt.run = cur.run + RUN_W'(1);
    end
    if (flip && obs_type) begin
      nxt.prio = 1'b1;
    end else if (flip) begin
      if (qual) begin
        nxt.cnt = (int'(cnt_sum) > CNT_MAX) ? CNT_W'(CNT_MAX) : cnt_sum[CNT_W-1:0];
      end else if (cur.cnt != '0) begin
        nxt.cnt = cur.cnt - CNT_W'(1);
      end
      nxt.prio = (nxt.cnt != '0);
    end
  end
endmodule

// File: rtl/line_store.sv
module line_store
  import tff_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_t         wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output line_st_t         rd_data
);
  line_st_t   mem [LINES];
  logic [LINES-1:0] sel;

  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign sel[g] = wr_en && (wr_idx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem[i] <= LINE_RST;
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (sel[i]) mem[i] <= wr_data;
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/type_flip_filter.sv
module type_flip_filter
  import tff_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = $clog2(LINES)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_line,
  input  logic             acc_type,
  output logic             res_valid,
  output logic             res_type,
  output logic             res_flip,
  output logic             res_prio,
  output logic [CNT_W-1:0] res_cnt
);
  line_st_t cur_st, nxt_st;
  logic     flip, qual;

  line_store #(.LINES(LINES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(acc_valid), .wr_idx(acc_line),
    .wr_data(nxt_st), .rd_idx(acc_line), .rd_data(cur_st));

  flip_rule u_rule (.cur(cur_st), .obs_type(acc_type), .nxt(nxt_st),
                    .flip(flip), .qual(qual));

  logic             valid_d;
  logic             type_d, flip_d, prio_d;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    valid_d = acc_valid;
    type_d  = res_type;
    flip_d  = res_flip;
    prio_d  = res_prio;
    cnt_d   = res_cnt;
    if (acc_valid) begin
      type_d = acc_type;
      flip_d = flip;
      prio_d = nxt_st.prio;
      cnt_d  = nxt_st.cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_type  <= 1'b0;
      res_flip  <= 1'b0;
      res_prio  <= 1'b0;
      res_cnt   <= '0;
    end else begin
      res_valid <= valid_d;
      res_type  <= type_d;
      res_flip  <= flip_d;
      res_prio  <= prio_d;
      res_cnt   <= cnt_d;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);
  // R3
  lead_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_flip && res_type) |-> res_prio);
  // R3
  lead_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && flip && acc_type) |=> (res_cnt == $past(cur_st.cnt)));
  // R6
  follow_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_flip && !res_type) |-> (res_prio == (res_cnt != '0)));
  // R7
  hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !flip) |=> (res_cnt == $past(cur_st.cnt) && res_prio == $past(cur_st.prio)));
  // R5
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && flip && !acc_type && !qual && cur_st.cnt == '0) |=> (res_cnt == '0));
endmodule

// File: tb/type_flip_filter_bench.sv
module type_flip_filter_bench;
  localparam int LINES = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic [3:0] acc_line = '0;
  logic       acc_type = 1'b0;
  logic       res_valid, res_type, res_flip, res_prio;
  logic [1:0] res_cnt;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  type_flip_filter #(.LINES(LINES)) u_type_flip_filter (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
    .acc_type(acc_type), .res_valid(res_valid), .res_type(res_type),
    .res_flip(res_flip), .res_prio(res_prio), .res_cnt(res_cnt));

  typedef struct {
    logic       f;
    logic       p;
    logic [1:0] c;
    int         kind;
  } exp_t;

  exp_t q[$];

  logic       m_type [LINES];
  int         m_run  [LINES];
  int         m_cnt  [LINES];
  logic       m_prio [LINES];

  function automatic string tag(int k);
    case (k)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      7: return "R7";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic access(int ln, logic t);
    exp_t e;
    @(negedge clk);
    e.f = (t != m_type[ln]);
    if (!e.f) begin
      e.kind = (m_run[ln] == 3 && m_cnt[ln] == 0 && !m_prio[ln] && !t) ? 1 : 7;
      if (m_run[ln] < 3) m_run[ln]++;
    end else if (t) begin
      e.kind = 3;
      m_prio[ln] = 1'b1;
      m_run[ln] = 1;
    end else begin
      if (m_run[ln] <= 2) begin
        e.kind = 4;
        m_cnt[ln] = (m_cnt[ln] + 2 > 3) ? 3 : m_cnt[ln] + 2;
      end else begin
        e.kind = 5;
        m_cnt[ln] = (m_cnt[ln] == 0) ? 0 : m_cnt[ln] - 1;
      end
      m_prio[ln] = (m_cnt[ln] != 0);
      m_run[ln] = 1;
    end
    m_type[ln] = t;
    e.p = m_prio[ln];
    e.c = 2'(m_cnt[ln]);
    q.push_back(e);
    acc_valid = 1'b1;
    acc_line  = 4'(ln);
    acc_type  = t;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      acc_valid = 1'b0;
    end
  endtask

  // monitor: pops expected items as results appear
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2", 1, 0, "unexpected res_valid");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(res_flip == e.f, (e.kind == 7 || e.kind == 1) ? "R7" : "R8", res_flip, e.f, "flip");
        chk(res_cnt == e.c, tag(e.kind), res_cnt, e.c, "score");
        chk(res_prio == e.p, (e.kind == 4 || e.kind == 5) ? "R6" : tag(e.kind), res_prio, e.p, "prio");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < LINES; i++) begin
      m_type[i] = 1'b0; m_run[i] = 3; m_cnt[i] = 0; m_prio[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1", res_valid, 0, "valid in reset");
    chk(res_prio == 1'b0 && res_cnt == 2'd0, "R1", res_cnt, 0, "outputs in reset");
    rst_n = 1'b1;
    idle(2);
    chk(res_valid == 1'b0, "R2", res_valid, 0, "valid with no access");

    // R1: fresh line read as following, long run, score 0
    access(0, 1'b0);
    // R4 then R3: short leading runs raise the score to saturation
    access(3, 1'b1); access(3, 1'b0);
    access(3, 1'b1); access(3, 1'b0);
    access(3, 1'b1); access(3, 1'b0);
    // R9: interleave another line between runs
    access(5, 1'b1); access(5, 1'b1);
    // R5/R8: long leading runs drain the score
    for (int k = 0; k < 5; k++) begin
      access(3, 1'b1); access(3, 1'b1); access(3, 1'b1); access(3, 1'b1);
      access(3, 1'b0);
    end
    // R8: run of exactly 2 qualifies, run of 3 does not
    access(5, 1'b0);
    access(7, 1'b1); access(7, 1'b1); access(7, 1'b1); access(7, 1'b0);
    // R7: repeated following accesses keep state
    access(5, 1'b0); access(5, 1'b0); access(5, 1'b0);
    idle(1);
    chk(res_valid == 1'b1, "R2", res_valid, 1, "valid after last access");
    idle(1);
    chk(res_valid == 1'b0, "R2", res_valid, 0, "valid after idle");

    lfsr = 16'hACE1;
    for (int n = 0; n < 2000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:6] == 2'b00) idle(1);
      else access(int'(lfsr[3:0] & 4'h7), lfsr[9] ^ lfsr[11]);
    end
    idle(3);
    chk(q.size() == 0, "R2", q.size(), 0, "results missing");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule